// File: doc/BRIEF.md
# Reset Sequencer and Source Classifier

This block is the reset controller of a small microcontroller. It merges four reset causes into one active-high core reset: power-on, a low level on the shared external reset pin, a watchdog timeout and a clock-monitor failure. It also returns a 2-bit code that picks the reset vector for the first program-counter fetch. Power-on and pin resets use the normal vector. The watchdog and the clock monitor each have a vector of their own.

The external reset line is open-drain and is shared with the board. When an internal cause fires, the block pulls the line low for a fixed number of E-clock ticks so that the rest of the board sees the reset. It then lets go, waits a fixed settling time and reads the line again. If the line has come back high, only this block was holding it, and the reset is classed as internal. If the line is still low, something outside is holding it. The reset is then treated as an external one and lasts until the line goes high. The pin level passes through a two-flop synchronizer before any use. After power-on, the core stays in reset for a parameterised number of E-clock ticks during which the oscillator is running, so that the clock can settle.

Top module: `reset_seq_top`

## Requirements
- R1: After power-on (rst_ni release or a por_i pulse), core_rst_o stays 1 until STABLE_CYC (default 4064) E ticks (e_en_i=1) have occurred while osc_ok_i=1. Ticks with osc_ok_i=0 are not counted.
- R2: If the synchronized pin is low when that delay ends, core_rst_o stays 1 until the pin is seen high. The vector is then 2'b00.
- R3: The vector code on vec_o is 2'b00 for normal (power-on or pin), 2'b01 for watchdog and 2'b10 for clock monitor. It is loaded only when core_rst_o falls and does not change while the core runs.
- R4: A watchdog or clock-monitor request while the core runs sets core_rst_o and drives pin_pd_o=1 for exactly DRIVE_E (default 4) E ticks.
- R5: After the pin is released, the block waits SAMPLE_E (default 2) E ticks plus the two synchronizer cycles, then reads the pin. If the pin is high, the core resumes with the internal vector. If it is low, the reset becomes external: core_rst_o holds until the pin is high, and the vector is 2'b00.
- R6: If watchdog and clock-monitor requests arrive in the same cycle, the clock monitor wins (vector 2'b10), and that source is kept through the whole pin sequence.
- R7: A falling edge of the synchronized pin while the core runs sets core_rst_o until the pin is seen high. The vector is then 2'b00.
- R8: Watchdog and clock-monitor requests that arrive while core_rst_o=1 are ignored. They cause no pin drive and no change of the vector.
- R9: A por_i pulse at any time restarts the power-on sequence and clears any pending internal source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low register reset (cold start) |
| por_i | input | 1 | Power-on detect pulse, restarts the sequence |
| osc_ok_i | input | 1 | Oscillator active; gates the stabilisation count |
| e_en_i | input | 1 | E-clock tick enable |
| pin_i | input | 1 | Raw level of the shared reset pin |
| wdog_req_i | input | 1 | Watchdog timeout pulse |
| cmon_req_i | input | 1 | Clock-monitor failure pulse |
| pin_pd_o | output | 1 | Open-drain pull-down enable for the reset pin |
| core_rst_o | output | 1 | Active-high reset to the core |
| vec_o | output | 2 | Reset vector select code |

## Verification
Two things can land in the same cycle: a watchdog request and a clock-monitor request. Separately, an internal request can coincide with an outside hold of the pin, so that the line is still low when the block reads it back. A vector table drives both requests in one cycle, with and without a bench-modelled external pull-down on the wired pin. It then checks the pull-down length, the release of the core and the vector against the priority and classification rules. Directed cases add a request during an external hold, an oscillator gap in the power-on count, and a power-on restart.

// File: rtl/reset_seq_pkg.sv
package reset_seq_pkg;
  typedef enum logic [1:0] {
    VEC_NORMAL = 2'b00,
    VEC_WDOG   = 2'b01,
    VEC_CLKMON = 2'b10
  } vec_e;

  typedef enum logic [2:0] {
    S_POR_WAIT,
    S_HOLD,
    S_RUN,
    S_DRIVE,
    S_SETTLE,
    S_SAMPLE
  } seq_state_e;
endpackage

// File: rtl/rsq_pin_sync.sv
module rsq_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic pin_s_o
);
  logic [STAGES-1:0] sync_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[g] <= 1'b1;
        else if (g == 0) sync_q[g] <= pin_i;
        else sync_q[g] <= sync_q[g-1];
      end
    end
  endgenerate

  assign pin_s_o = sync_q[STAGES-1];

  logic [1:0] vld_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_q <= '0;
    else if (vld_q != 2'd3) vld_q <= vld_q + 2'd1;
  end

  // R7: synchronized level trails the raw pin by two clocks
  p_sync_lat_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_q == 2'd3) |-> (pin_s_o == $past(pin_i, STAGES)));
endmodule

// File: rtl/rsq_src_arb.sv
module rsq_src_arb
  import reset_seq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cap_i,
  input  logic clr_i,
  input  logic wdog_i,
  input  logic cmon_i,
  output vec_e src_o
);
  vec_e src_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) src_q <= VEC_NORMAL;
    else if (clr_i) src_q <= VEC_NORMAL;
    else if (cap_i && cmon_i) src_q <= VEC_CLKMON;
    else if (cap_i && wdog_i) src_q <= VEC_WDOG;
  end

  assign src_o = src_q;

  p_cm_prio_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_i && cmon_i && !clr_i) |=> (src_o == VEC_CLKMON));
  p_keep_src_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cap_i && !clr_i) |=> $stable(src_o));
endmodule

// File: rtl/rsq_fsm.sv
module rsq_fsm
  import reset_seq_pkg::*;
#(
  parameter int STABLE_CYC = 4064,
  parameter int DRIVE_E    = 4,
  parameter int SAMPLE_E   = 2,
  parameter int SYNC_STG   = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       por_i,
  input  logic       osc_ok_i,
  input  logic       e_en_i,
  input  logic       pin_s_i,
  input  logic       req_i,
  input  vec_e       src_i,
  output logic       cap_o,
  output logic       clr_o,
  output logic       pin_pd_o,
  output logic       core_rst_o,
  output logic [1:0] vec_o
);
  localparam int CNT_MAX = (STABLE_CYC > DRIVE_E) ? STABLE_CYC : DRIVE_E;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] STABLE_LAST = CNT_W'(STABLE_CYC - 1);
  localparam logic [CNT_W-1:0] DRIVE_LAST  = CNT_W'(DRIVE_E - 1);
  localparam logic [CNT_W-1:0] SAMPLE_LAST = CNT_W'(SAMPLE_E - 1);
  localparam logic [CNT_W-1:0] SYNC_LAST   = CNT_W'(SYNC_STG - 1);

  seq_state_e state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic pin_prev_q;
  vec_e vec_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cap_o   = 1'b0;
    clr_o   = 1'b0;
    unique case (state_q)
      S_POR_WAIT: if (e_en_i && osc_ok_i) begin
        if (cnt_q == STABLE_LAST) begin state_d = S_HOLD; cnt_d = '0; end
        else cnt_d = cnt_q + 1'b1;
      end
      S_HOLD: if (pin_s_i) state_d = S_RUN;
      S_RUN: begin
        if (req_i) begin
          state_d = S_DRIVE; cnt_d = '0; cap_o = 1'b1;
        end else if (pin_prev_q && !pin_s_i) begin
          state_d = S_HOLD; clr_o = 1'b1;
        end
      end
      S_DRIVE: if (e_en_i) begin
        if (cnt_q == DRIVE_LAST) begin state_d = S_SETTLE; cnt_d = '0; end
        else cnt_d = cnt_q + 1'b1;
      end
      S_SETTLE: if (e_en_i) begin
        if (cnt_q == SAMPLE_LAST) begin state_d = S_SAMPLE; cnt_d = '0; end
        else cnt_d = cnt_q + 1'b1;
      end
      S_SAMPLE: begin
        // wait out the synchronizer, then classify
        if (cnt_q == SYNC_LAST) begin
          cnt_d = '0;
          if (pin_s_i) state_d = S_RUN;
          else begin state_d = S_HOLD; clr_o = 1'b1; end
        end else cnt_d = cnt_q + 1'b1;
      end
      default: state_d = S_POR_WAIT;
    endcase
    if (por_i) begin
      state_d = S_POR_WAIT; cnt_d = '0; clr_o = 1'b1; cap_o = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_POR_WAIT;
      cnt_q      <= '0;
      pin_prev_q <= 1'b1;
      vec_q      <= VEC_NORMAL;
    end else begin
      state_q    <= state_d;
      cnt_q      <= cnt_d;
      pin_prev_q <= pin_s_i;
      if (state_d == S_RUN && state_q != S_RUN)
        vec_q <= clr_o ? VEC_NORMAL : src_i;
    end
  end

  assign pin_pd_o   = (state_q == S_DRIVE);
  assign core_rst_o = (state_q != S_RUN);
  assign vec_o      = vec_q;

  p_por_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_POR_WAIT && !(e_en_i && osc_ok_i)) |=> core_rst_o);
  p_release_pin_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(core_rst_o) |-> $past(pin_s_i));
  p_vec_stable_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!core_rst_o && $past(!core_rst_o)) |-> $stable(vec_o));
  p_drive_len_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_pd_o && !(e_en_i && cnt_q == DRIVE_LAST) && !por_i) |=> pin_pd_o);
  p_no_drive_in_rst_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pin_pd_o) |-> $past(!core_rst_o));
  p_por_restart_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    por_i |=> (core_rst_o && !pin_pd_o));
endmodule

// File: rtl/reset_seq_top.sv
module reset_seq_top
  import reset_seq_pkg::*;
#(
  parameter int STABLE_CYC = 4064,
  parameter int DRIVE_E    = 4,
  parameter int SAMPLE_E   = 2,
  parameter int SYNC_STG   = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       por_i,
  input  logic       osc_ok_i,
  input  logic       e_en_i,
  input  logic       pin_i,
  input  logic       wdog_req_i,
  input  logic       cmon_req_i,
  output logic       pin_pd_o,
  output logic       core_rst_o,
  output logic [1:0] vec_o
);
  logic pin_s, cap, clr;
  vec_e src;

  rsq_pin_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(pin_i), .pin_s_o(pin_s)
  );

  rsq_src_arb u_arb (
    .clk_i(clk_i), .rst_ni(rst_ni), .cap_i(cap), .clr_i(clr),
    .wdog_i(wdog_req_i), .cmon_i(cmon_req_i), .src_o(src)
  );

  rsq_fsm #(
    .STABLE_CYC(STABLE_CYC), .DRIVE_E(DRIVE_E),
    .SAMPLE_E(SAMPLE_E), .SYNC_STG(SYNC_STG)
  ) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .por_i(por_i), .osc_ok_i(osc_ok_i),
    .e_en_i(e_en_i), .pin_s_i(pin_s), .req_i(wdog_req_i | cmon_req_i),
    .src_i(src), .cap_o(cap), .clr_o(clr), .pin_pd_o(pin_pd_o),
    .core_rst_o(core_rst_o), .vec_o(vec_o)
  );

  p_pd_in_reset_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_pd_o |-> core_rst_o);
endmodule

// File: tb/reset_seq_top_tb_top.sv
module reset_seq_top_tb_top;
  localparam int STABLE = 4064;
  localparam int DRV    = 4;

  logic clk = 1'b0, rst_n = 1'b0, por = 1'b0, osc_ok = 1'b0, e_en = 1'b1;
  logic wd = 1'b0, cm = 1'b0, ext_low = 1'b0;
  logic pin_pd, core_rst;
  logic [1:0] vec;
  wire pin = !(ext_low || pin_pd);

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  reset_seq_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .por_i(por), .osc_ok_i(osc_ok),
    .e_en_i(e_en), .pin_i(pin), .wdog_req_i(wd), .cmon_req_i(cm),
    .pin_pd_o(pin_pd), .core_rst_o(core_rst), .vec_o(vec)
  );

  // {wdog, cmon, ext_hold, expected vector}
  localparam logic [4:0] TAB [6] = '{
    {1'b1, 1'b0, 1'b0, 2'b01},
    {1'b0, 1'b1, 1'b0, 2'b10},
    {1'b1, 1'b1, 1'b0, 2'b10},
    {1'b1, 1'b0, 1'b1, 2'b00},
    {1'b0, 1'b1, 1'b1, 2'b00},
    {1'b1, 1'b1, 1'b1, 2'b00}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_run(output int cyc);
    cyc = 0;
    while (core_rst && cyc < 6000) begin @(negedge clk); cyc++; end
  endtask

  initial begin
    int c, pd, still;
    @(negedge clk);
    chk("R1 reset state core_rst", core_rst, 1);
    chk("R1 reset state pin_pd", pin_pd, 0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    chk("R1 no count without oscillator", core_rst, 1);
    // R1: oscillator on, with a 50-cycle gap midway
    osc_ok = 1'b1;
    c = 0;
    repeat (2000) begin @(negedge clk); c++; end
    osc_ok = 1'b0;
    repeat (50) begin @(negedge clk); c++; end
    osc_ok = 1'b1;
    while (core_rst && c < 8000) begin @(negedge clk); c++; end
    n_chk++;
    if (c < STABLE + 50 || c > STABLE + 52) begin
      n_fail++;
      $display("FAIL R1 release cycles actual=%0d expected=%0d", c, STABLE + 51);
    end
    chk("R3 power-on vector", vec, 0);

    // table walk: R4 R5 R6 R3
    for (int i = 0; i < 6; i++) begin
      wd = TAB[i][4]; cm = TAB[i][3];
      @(negedge clk);
      wd = 1'b0; cm = 1'b0;
      if (TAB[i][2]) ext_low = 1'b1;
      pd = 0;
      for (int k = 0; k < 30; k++) begin
        if (pin_pd) pd++;
        @(negedge clk);
      end
      chk("R4 pull-down length", pd, DRV);
      still = core_rst;
      chk("R5 core in reset while pin held", still, TAB[i][2]);
      ext_low = 1'b0;
      wait_run(c);
      chk("R5 core released", core_rst, 0);
      chk("R6 R3 vector", vec, TAB[i][1:0]);
      repeat (5) @(negedge clk);
    end

    // R7: falling pin edge while running
    wd = 1'b1; @(negedge clk); wd = 1'b0;
    wait_run(c);
    chk("R3 watchdog vector before pin reset", vec, 1);
    ext_low = 1'b1;
    repeat (4) @(negedge clk);
    chk("R7 pin edge asserts core reset", core_rst, 1);
    // R8: requests during reset ignored
    wd = 1'b1; cm = 1'b1;
    repeat (2) @(negedge clk);
    wd = 1'b0; cm = 1'b0;
    pd = 0;
    for (int k = 0; k < 20; k++) begin
      if (pin_pd) pd++;
      @(negedge clk);
    end
    chk("R8 no pull-down during reset", pd, 0);
    chk("R7 held while pin low", core_rst, 1);
    ext_low = 1'b0;
    wait_run(c);
    n_chk++;
    if (c > 4) begin
      n_fail++;
      $display("FAIL R7 release latency actual=%0d expected=3", c);
    end
    chk("R7 R8 vector normal", vec, 0);

    // R9: power-on restart after an internal reset
    cm = 1'b1; @(negedge clk); cm = 1'b0;
    wait_run(c);
    chk("R3 clock-monitor vector", vec, 2);
    por = 1'b1; @(negedge clk); por = 1'b0;
    chk("R9 restart asserts core reset", core_rst, 1);
    repeat (STABLE - 10) @(negedge clk);
    chk("R9 still in stabilisation", core_rst, 1);
    // R2: pin held low at end of delay
    ext_low = 1'b1;
    repeat (200) @(negedge clk);
    chk("R2 held past delay while pin low", core_rst, 1);
    ext_low = 1'b0;
    wait_run(c);
    n_chk++;
    if (c > 4) begin
      n_fail++;
      $display("FAIL R2 release latency actual=%0d expected=3", c);
    end
    chk("R2 R9 vector normal", vec, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog timeout actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule